// File: doc/BRIEF.md
# BCD Calendar Counter with 12/24-Hour Mode

This block keeps wall-clock time and date in packed BCD registers. A free-running base tick is divided by a sub-second prescaler. Every time the prescaler completes a second, a small carry-walk state machine advances the seconds field. When a field rolls over, the machine moves on to the next field one clock later. The chain runs through minutes, hours, the weekday and day-of-month pair, the month and finally the year. Hours are counted either in 24-hour form or in 12-hour form with a PM flag, chosen by a control bit. A century flag kept in the top bit of the month register flips whenever the two-digit year wraps.

Software sets the time through a parallel load port that replaces every time field on one clock edge. The same load restarts the sub-second phase. Two control registers hold the hour-mode select and an oscillator-stop flag. The flag reads 1 after reset to show that the time is not yet valid, and software clears it by a write. A combinational read port returns any register by address.

Walk states: ST_IDLE waits for a second. ST_SEC, ST_MIN, ST_HOUR, ST_DATE (weekday and day together), ST_MONTH and ST_YEAR each step one field. Each of these moves to the next field's state when its field wrapped, and otherwise returns to ST_IDLE. ST_YEAR always returns to ST_IDLE. A load forces ST_IDLE from any state.

Top module: `bcd_rtc_core`

## Requirements
- R1: Seconds (address 0) and minutes (address 1) are packed BCD, tens in bits 7:4 and units in bits 3:0. A step adds one with a decimal carry from units into tens, so 0x09 becomes 0x10. A step from 0x59 gives 0x00 and carries into the next field.
- R2: When bit 5 of control register 1 (address 14) is 1, the hour (address 2) counts 0x00 to 0x23 in BCD. A step from 0x23 gives 0x00 and carries into the day.
- R3: When that bit is 0, hour bit 5 is the PM flag and bits 4:0 hold 1 to 12 in BCD. A step from 11 gives 12 and toggles PM. A step from 12 gives 01 with PM unchanged. Only the step from PM 11 to AM 12 carries into the day, so midnight reads 0x12 and noon reads 0x32.
- R4: The day of month (address 4) wraps to 0x01 after the last day of the month, which is 0x31, 0x30 for months 04, 06, 09 and 11, and for 02 either 0x29 when the two-digit year is divisible by 4 or 0x28 otherwise. Each day step also advances the weekday (address 3) from 0 to 6 and back to 0.
- R5: The month (address 5, bits 4:0) wraps from 0x12 to 0x01 and carries into the year (address 6). The year wraps from 0x99 to 0x00 and toggles the century flag in month bit 7. That bit is otherwise preserved.
- R6: The seconds field steps once for every TICKS_PER_SEC base ticks. Fewer base ticks since the last second leave all fields unchanged.
- R7: A load replaces all seven time fields on one clock edge, restarts the sub-second phase from zero and ends any carry walk in progress. The next second follows exactly TICKS_PER_SEC base ticks after the load.
- R8: The oscillator-stop flag is bit 4 of control register 2 (address 15). It reads 1 after reset. Writing that register with bit 4 at 0 clears it. Writing it with bit 4 at 1 leaves it unchanged.
- R9: After reset every time field reads 0x00 and control register 1 reads 0x00 (12-hour mode). Addresses 7 to 13 always read 0x00, as do the unused bits of the control registers.
- R10: The carry walk steps one field per clock cycle and settles within six cycles of a second. No second may arrive while the walk is busy, so TICKS_PER_SEC must be at least 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | Sub-second tick, one pulse per clock at most |
| ld_en | input | 1 | Parallel load strobe for all time fields |
| ld_sec | input | 8 | Seconds value to load (BCD) |
| ld_min | input | 8 | Minutes value to load (BCD) |
| ld_hour | input | 8 | Hour value to load, in the current hour format |
| ld_wday | input | 8 | Weekday value to load (0 to 6) |
| ld_day | input | 8 | Day-of-month value to load (BCD) |
| ld_month | input | 8 | Month value to load, century flag in bit 7 |
| ld_year | input | 8 | Two-digit year value to load (BCD) |
| ctl_we | input | 1 | Control register write strobe |
| ctl_sel | input | 1 | Control register select: 0 register 1, 1 register 2 |
| ctl_wdata | input | 8 | Control register write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data for rd_addr, combinational |

## Verification
The hardest case to reach from the ports is a carry that runs through all six walk states in one second. This happens at 23:59:59 on the last day of December in year 99, where the century flag must flip while month and year both wrap. Counting up to that moment would take far too many seconds, so the bench loads the time one second before each boundary and gives exactly one second of base ticks. It does the same for the leap-year end of February, the 12-hour noon and midnight crossings, and a 30-day month.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEC,
        ST_MIN,
        ST_HOUR,
        ST_DATE,
        ST_MONTH,
        ST_YEAR
    } walk_state_t;

    localparam int FIELD_W     = 8;
    localparam int MODE24_BIT  = 5;
    localparam int PM_BIT      = 5;
    localparam int CENTURY_BIT = 7;
    localparam int OSCSTOP_BIT = 4;

    localparam logic [3:0] ADDR_SEC   = 4'd0;
    localparam logic [3:0] ADDR_MIN   = 4'd1;
    localparam logic [3:0] ADDR_HOUR  = 4'd2;
    localparam logic [3:0] ADDR_WDAY  = 4'd3;
    localparam logic [3:0] ADDR_MDAY  = 4'd4;
    localparam logic [3:0] ADDR_MONTH = 4'd5;
    localparam logic [3:0] ADDR_YEAR  = 4'd6;
    localparam logic [3:0] ADDR_CTL1  = 4'd14;
    localparam logic [3:0] ADDR_CTL2  = 4'd15;

    typedef struct packed {
        logic [FIELD_W-1:0] seconds;
        logic [FIELD_W-1:0] minutes;
        logic [FIELD_W-1:0] hours;
        logic [FIELD_W-1:0] wday;
        logic [FIELD_W-1:0] mday;
        logic [FIELD_W-1:0] month;
        logic [FIELD_W-1:0] year;
    } time_regs_t;

    // Add one to a packed BCD byte.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two-digit BCD year divisible by four.
    function automatic logic leap_year(input logic [7:0] y);
        if (y[4])
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else
            return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    // Last day of a month, in BCD; the century flag is ignored.
    function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
        logic [7:0] mm;
        mm = {3'b000, m[4:0]};
        case (mm)
            8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_rtc_prescaler.sv
module bcd_rtc_prescaler #(
    parameter int TICKS_PER_SEC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_tick,
    input  logic restart,
    output logic sec_pulse
);
    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            phase_q <= '0;
        else if (base_tick)
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end

    assign sec_pulse = base_tick && !restart && (phase_q == LAST);

    // R6
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST);

    // R7
    restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0));

endmodule

// File: rtl/bcd_rtc_walker.sv
module bcd_rtc_walker
    import bcd_rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_pulse,
    input  logic        load,
    input  logic        carry,
    output walk_state_t state,
    output logic        busy
);
    walk_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = sec_pulse ? ST_SEC : ST_IDLE;
                ST_SEC:   state_d = carry ? ST_MIN   : ST_IDLE;
                ST_MIN:   state_d = carry ? ST_HOUR  : ST_IDLE;
                ST_HOUR:  state_d = carry ? ST_DATE  : ST_IDLE;
                ST_DATE:  state_d = carry ? ST_MONTH : ST_IDLE;
                ST_MONTH: state_d = carry ? ST_YEAR  : ST_IDLE;
                ST_YEAR:  state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        state = state_q;
        busy  = (state_q != ST_IDLE);
    end

    // R10
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> (state_q == ST_IDLE));

    // R7
    load_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q == ST_IDLE));

    // R10
    start_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !load) |=> (state_q == ST_SEC));

endmodule

// File: rtl/bcd_rtc_fields.sv
module bcd_rtc_fields
    import bcd_rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  walk_state_t state,
    input  logic        mode24,
    input  logic        load,
    input  time_regs_t  load_val,
    output time_regs_t  regs,
    output logic        carry
);
    time_regs_t regs_q, regs_d;
    logic [7:0] hour12_inc;
    logic [7:0] month_inc;

    always_comb begin
        hour12_inc = bcd_inc({3'b000, regs_q.hours[4:0]});
        month_inc  = bcd_inc({3'b000, regs_q.month[4:0]});
    end

    always_comb begin
        regs_d = regs_q;
        carry  = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_SEC: begin
                if (regs_q.seconds == 8'h59) begin
                    regs_d.seconds = 8'h00;
                    carry          = 1'b1;
                end else begin
                    regs_d.seconds = bcd_inc(regs_q.seconds);
                end
            end
            ST_MIN: begin
                if (regs_q.minutes == 8'h59) begin
                    regs_d.minutes = 8'h00;
                    carry          = 1'b1;
                end else begin
                    regs_d.minutes = bcd_inc(regs_q.minutes);
                end
            end
            ST_HOUR: begin
                if (mode24) begin
                    if (regs_q.hours == 8'h23) begin
                        regs_d.hours = 8'h00;
                        carry        = 1'b1;
                    end else begin
                        regs_d.hours = bcd_inc(regs_q.hours);
                    end
                end else if (regs_q.hours[4:0] == 5'h11) begin
                    regs_d.hours = {2'b00, ~regs_q.hours[PM_BIT], 5'h12};
                    carry        = regs_q.hours[PM_BIT];
                end else if (regs_q.hours[4:0] == 5'h12) begin
                    regs_d.hours = {2'b00, regs_q.hours[PM_BIT], 5'h01};
                end else begin
                    regs_d.hours = {2'b00, regs_q.hours[PM_BIT], hour12_inc[4:0]};
                end
            end
            ST_DATE: begin
                regs_d.wday = (regs_q.wday >= 8'd6) ? 8'd0 : regs_q.wday + 8'd1;
                if (regs_q.mday == last_day(regs_q.month, regs_q.year)) begin
                    regs_d.mday = 8'h01;
                    carry       = 1'b1;
                end else begin
                    regs_d.mday = bcd_inc(regs_q.mday);
                end
            end
            ST_MONTH: begin
                if (regs_q.month[4:0] == 5'h12) begin
                    regs_d.month = {regs_q.month[CENTURY_BIT], 7'h01};
                    carry        = 1'b1;
                end else begin
                    regs_d.month = {regs_q.month[CENTURY_BIT], 2'b00, month_inc[4:0]};
                end
            end
            ST_YEAR: begin
                if (regs_q.year == 8'h99) begin
                    regs_d.year                = 8'h00;
                    regs_d.month[CENTURY_BIT]  = ~regs_q.month[CENTURY_BIT];
                    carry                      = 1'b1;
                end else begin
                    regs_d.year = bcd_inc(regs_q.year);
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            regs_q <= '0;
        else if (load)
            regs_q <= load_val;
        else if (state != ST_IDLE)
            regs_q <= regs_d;
    end

    assign regs = regs_q;

    // R1
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEC && !load && regs_q.seconds == 8'h59) |=> (regs_q.seconds == 8'h00));

    // R3
    pm_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOUR && !load && !mode24 && regs_q.hours[4:0] == 5'h11)
        |=> (regs_q.hours[PM_BIT] != $past(regs_q.hours[PM_BIT])));

    // R5
    century_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_YEAR && !load && regs_q.year == 8'h99)
        |=> (regs_q.month[CENTURY_BIT] != $past(regs_q.month[CENTURY_BIT])));

    // R7
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (regs_q == $past(load_val)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !load) |=> $stable(regs_q));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import bcd_rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_tick,
    input  logic       ld_en,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_wday,
    input  logic [7:0] ld_day,
    input  logic [7:0] ld_month,
    input  logic [7:0] ld_year,
    input  logic       ctl_we,
    input  logic       ctl_sel,
    input  logic [7:0] ctl_wdata,
    input  logic [3:0] rd_addr,
    output logic [7:0] rd_data
);
    logic        sec_pulse;
    logic        carry;
    logic        busy;
    walk_state_t state;
    time_regs_t  regs;
    time_regs_t  load_val;
    logic        mode24_q;
    logic        osc_stop_q;

    assign load_val = '{seconds: ld_sec, minutes: ld_min, hours: ld_hour,
                        wday: ld_wday, mday: ld_day, month: ld_month, year: ld_year};

    bcd_rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .restart   (ld_en),
        .sec_pulse (sec_pulse)
    );

    bcd_rtc_walker u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_pulse (sec_pulse),
        .load      (ld_en),
        .carry     (carry),
        .state     (state),
        .busy      (busy)
    );

    bcd_rtc_fields u_fields (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .mode24   (mode24_q),
        .load     (ld_en),
        .load_val (load_val),
        .regs     (regs),
        .carry    (carry)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode24_q   <= 1'b0;
            osc_stop_q <= 1'b1;
        end else if (ctl_we) begin
            if (!ctl_sel)
                mode24_q <= ctl_wdata[MODE24_BIT];
            else if (!ctl_wdata[OSCSTOP_BIT])
                osc_stop_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        unique case (rd_addr)
            ADDR_SEC:   rd_data = regs.seconds;
            ADDR_MIN:   rd_data = regs.minutes;
            ADDR_HOUR:  rd_data = regs.hours;
            ADDR_WDAY:  rd_data = regs.wday;
            ADDR_MDAY:  rd_data = regs.mday;
            ADDR_MONTH: rd_data = regs.month;
            ADDR_YEAR:  rd_data = regs.year;
            ADDR_CTL1:  rd_data = 8'(mode24_q) << MODE24_BIT;
            ADDR_CTL2:  rd_data = 8'(osc_stop_q) << OSCSTOP_BIT;
            default:    rd_data = 8'h00;
        endcase
    end

    // R8
    osc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_sel && !ctl_wdata[OSCSTOP_BIT]) |=> !osc_stop_q);

    // R8
    osc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_we && ctl_sel && !ctl_wdata[OSCSTOP_BIT]) |=> (osc_stop_q == $past(osc_stop_q)));

    // R10
    walk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sec_pulse);

endmodule

// File: tb/test_bcd_rtc_core.sv
`timescale 1ns/1ps
module test_bcd_rtc_core;
    localparam int T = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       ld_en = 1'b0;
    logic [7:0] ld_sec = 8'h00, ld_min = 8'h00, ld_hour = 8'h00, ld_wday = 8'h00;
    logic [7:0] ld_day = 8'h00, ld_month = 8'h00, ld_year = 8'h00;
    logic       ctl_we = 1'b0;
    logic       ctl_sel = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [3:0] rd_addr = 4'd0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    int outstanding = 0;
    bit finished = 0;

    logic [3:0] q_addr[$];
    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #4 clk = ~clk;

    bcd_rtc_core #(.TICKS_PER_SEC(T)) i_bcd_rtc_core (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .ld_en(ld_en),
        .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_wday(ld_wday),
        .ld_day(ld_day), .ld_month(ld_month), .ld_year(ld_year),
        .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Monitor: pops expected items and compares at the read port.
    initial begin
        forever begin
            logic [3:0] a;
            logic [7:0] e;
            string      t;
            wait (q_addr.size() > 0);
            a = q_addr.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            @(negedge clk);
            rd_addr = a;
            #1;
            checks++;
            if (rd_data !== e) begin
                errors++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", t, a, rd_data, e);
            end
            outstanding--;
        end
    end

    task automatic expect_reg(input logic [3:0] a, input logic [7:0] e, input string t);
        outstanding++;
        q_addr.push_back(a);
        q_exp.push_back(e);
        q_tag.push_back(t);
    endtask

    task automatic flush();
        wait (outstanding == 0);
        @(negedge clk);
    endtask

    task automatic base_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            base_tick = 1'b1;
        end
        @(negedge clk);
        base_tick = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic load_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                             input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                             input logic [7:0] y);
        @(negedge clk);
        ld_sec = s; ld_min = m; ld_hour = h; ld_wday = w;
        ld_day = d; ld_month = mo; ld_year = y;
        ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic ctl_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        ctl_sel = sel; ctl_wdata = d; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state and unused addresses
        for (int a = 0; a < 7; a++) expect_reg(4'(a), 8'h00, "R9 reset field");
        expect_reg(4'd7, 8'h00, "R9 unused addr");
        expect_reg(4'd13, 8'h00, "R9 unused addr");
        expect_reg(4'd14, 8'h00, "R9 ctl1 12h");
        // R8 flag set after reset
        expect_reg(4'd15, 8'h10, "R8 osc flag after reset");
        flush();

        // R8 write with bit4=1 keeps flag, bit4=0 clears it
        ctl_write(1'b1, 8'h10);
        expect_reg(4'd15, 8'h10, "R8 write one keeps");
        flush();
        ctl_write(1'b1, 8'hEF);
        expect_reg(4'd15, 8'h00, "R8 write zero clears");
        flush();

        // R1 decimal carry 09 -> 10, R6 no step before a full second
        ctl_write(1'b0, 8'h20);
        expect_reg(4'd14, 8'h20, "R2 ctl1 24h readback");
        load_time(8'h09, 8'h00, 8'h10, 8'd2, 8'h15, 8'h86, 8'h24);
        base_ticks(T - 1);
        expect_reg(4'd0, 8'h09, "R6 partial second no step");
        flush();
        base_ticks(1);
        expect_reg(4'd0, 8'h10, "R1 units carry to tens");
        expect_reg(4'd1, 8'h00, "R1 minute unchanged");
        flush();

        // R7 load restarts sub-second phase
        base_ticks(5);
        load_time(8'h30, 8'h00, 8'h10, 8'd2, 8'h15, 8'h86, 8'h24);
        base_ticks(T - 1);
        expect_reg(4'd0, 8'h30, "R7 phase restarted");
        flush();
        base_ticks(1);
        expect_reg(4'd0, 8'h31, "R7 second after full period");
        flush();

        // R1 R2 R4 R5 full carry with century set from clear
        load_time(8'h58, 8'h59, 8'h23, 8'd6, 8'h31, 8'h12, 8'h99);
        base_ticks(T);
        expect_reg(4'd0, 8'h59, "R1 plain step");
        flush();
        base_ticks(T);
        expect_reg(4'd0, 8'h00, "R1 sec wrap");
        expect_reg(4'd1, 8'h00, "R1 min wrap");
        expect_reg(4'd2, 8'h00, "R2 hour 23 wraps");
        expect_reg(4'd3, 8'h00, "R4 weekday 6 wraps");
        expect_reg(4'd4, 8'h01, "R4 day 31 wraps");
        expect_reg(4'd5, 8'h81, "R5 month wrap century set");
        expect_reg(4'd6, 8'h00, "R5 year 99 wraps");
        flush();

        // R5 century flag toggles back off
        load_time(8'h59, 8'h59, 8'h23, 8'd3, 8'h31, 8'h92, 8'h99);
        base_ticks(T);
        expect_reg(4'd5, 8'h01, "R5 century toggles off");
        expect_reg(4'd6, 8'h00, "R5 year wrap");
        flush();

        // R4 leap February
        load_time(8'h59, 8'h59, 8'h23, 8'd1, 8'h28, 8'h82, 8'h24);
        base_ticks(T);
        expect_reg(4'd4, 8'h29, "R4 leap feb 28 to 29");
        expect_reg(4'd5, 8'h82, "R4 month kept");
        expect_reg(4'd3, 8'h02, "R4 weekday step");
        flush();
        load_time(8'h59, 8'h59, 8'h23, 8'd1, 8'h28, 8'h82, 8'h10);
        base_ticks(T);
        expect_reg(4'd4, 8'h01, "R4 non-leap feb 28 wraps");
        expect_reg(4'd5, 8'h83, "R4 month advance");
        flush();
        load_time(8'h59, 8'h59, 8'h23, 8'd1, 8'h30, 8'h84, 8'h25);
        base_ticks(T);
        expect_reg(4'd4, 8'h01, "R4 30-day month wraps");
        expect_reg(4'd5, 8'h85, "R4 april to may");
        expect_reg(4'd6, 8'h25, "R5 year unchanged");
        flush();

        // R3 12-hour mode
        ctl_write(1'b0, 8'h00);
        load_time(8'h59, 8'h59, 8'h11, 8'd0, 8'h05, 8'h86, 8'h24);
        base_ticks(T);
        expect_reg(4'd2, 8'h32, "R3 AM 11 to noon PM 12");
        expect_reg(4'd4, 8'h05, "R3 noon no day carry");
        flush();
        load_time(8'h59, 8'h59, 8'h32, 8'd0, 8'h05, 8'h86, 8'h24);
        base_ticks(T);
        expect_reg(4'd2, 8'h21, "R3 PM 12 to PM 1");
        flush();
        load_time(8'h59, 8'h59, 8'h31, 8'd0, 8'h05, 8'h86, 8'h24);
        base_ticks(T);
        expect_reg(4'd2, 8'h12, "R3 PM 11 to midnight AM 12");
        expect_reg(4'd4, 8'h06, "R3 midnight day carry");
        flush();
        load_time(8'h59, 8'h59, 8'h09, 8'd0, 8'h05, 8'h86, 8'h24);
        base_ticks(T);
        expect_reg(4'd2, 8'h10, "R3 AM 9 to 10");
        flush();

        // R10 walk settles: a second after a full carry steps normally
        base_ticks(T);
        expect_reg(4'd0, 8'h01, "R10 next second after walk");
        expect_reg(4'd2, 8'h10, "R10 hour held");
        flush();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule